// File: doc/BRIEF.md
# Clause 22 MDIO Management Master with Port-Relative Addressing

This block is the management-bus master that a network controller uses to read and write the registers of its attached Ethernet PHYs over the two-wire MDC/MDIO bus. A host issues a single request. The request carries a logical port number, a 5-bit register number, a direction flag and, for writes, a 16-bit value. The block turns the port number into a bus address by adding a programmable 5-bit base. It then clocks out one complete clause 22 frame and, on reads, returns the 16 bits the PHY shifted back.

The management clock is derived from the system clock by a half-period divider. The divider is never allowed below the value that keeps MDC at or under 25 MHz. MDC toggles only while a frame is in flight and rests high otherwise. The data pin is split into output, output-enable and input, so that the pad ring can build the open-drain style tri-state with an external pull-up.

Top module: `mdio_port_master`

## Requirements
- R1: While a frame is in flight, MDC has a period of 2*H system cycles, each half lasting H cycles, where H is the larger of the MDC_HALF parameter and ceil(SYS_CLK_HZ / 50 MHz). MDC therefore never exceeds 25 MHz. With the defaults (50 MHz, MDC_HALF=2) the period is 4 cycles.
- R2: MDC is high whenever no frame is in flight, including after reset.
- R3: The master changes its MDIO output or output enable only together with a falling edge of MDC, so the line is stable at every MDC rising edge.
- R4: mdio_oe is low (line released) whenever the block is not busy.
- R5: The bus address equals (port number + addr_offset) modulo 32.
- R6: A write frame is 64 MDC cycles, sent in this order: 32 ones, start bits 0 then 1, opcode 0 then 1, the 5 address bits MSB first, the 5 register bits MSB first, turnaround 1 then 0, and the 16 data bits MSB first.
- R7: A read frame carries opcode 1 then 0. The master drives the first 46 bits and keeps mdio_oe low from the turnaround (bit 46 of 0..63) to the end of the frame.
- R8: On a read, the 16 values of mdio_i present at the MDC rising edges of bits 48..63 form rd_data, MSB first. rd_data is updated in the done cycle.
- R9: busy rises in the cycle after an accepted request (req_valid while not busy). While busy, further requests are ignored and do not alter the frame in flight.
- R10: done is a single-cycle pulse at the end of the frame, and busy is low in that same cycle.
- R11: rd_data resets to 0 and changes only when a read completes. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_port | input | PORT_W | Logical port number |
| req_reg | input | 5 | PHY register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write value |
| addr_offset | input | 5 | Base added to the port number |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Data from the last completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
Two functions can meet in the same cycle: accepting a new request and running a frame already in flight. The bench provokes this by pulsing req_valid with different port, register and direction values in the middle of a write. It judges the outcome at the bus by capturing the whole frame on MDC rising edges and comparing it bit for bit with the frame built from the original request alone. A read is followed by a write to confirm that the read result survives the next frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;

  // Bus address: port plus base, wrapping at 32.
  function automatic logic [4:0] bus_addr(input logic [4:0] port5, input logic [4:0] base);
    return port5 + base;
  endfunction

  // Whole frame, first transmitted bit in the MSB.
  function automatic logic [FRAME_BITS-1:0] make_frame(input logic wr, input logic [4:0] pa,
                                                       input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra,
            (wr ? 2'b10 : 2'b11), (wr ? wd : 16'h0000)};
  endfunction

  // Smallest half period (in system cycles) that keeps MDC at or under 25 MHz.
  function automatic int unsigned min_half(input int unsigned sys_hz);
    return (sys_hz + 32'd49_999_999) / 32'd50_000_000;
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic bit_start,
  output logic sample_tick,
  output logic bit_end
);
  localparam int unsigned PER = 2 * HALF;
  localparam int CW = (PER > 2) ? $clog2(PER) : 1;

  logic [CW-1:0] cnt;
  logic          mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      mdc_q <= 1'b1;
    end else begin
      cnt   <= (cnt == CW'(PER - 1)) ? '0 : cnt + 1'b1;
      mdc_q <= (cnt >= CW'(HALF));
    end
  end

  assign mdc         = mdc_q;
  assign bit_start   = run && (cnt == '0);
  assign sample_tick = run && (cnt == CW'(HALF));
  assign bit_end     = run && (cnt == CW'(PER - 1));

  // Low-phase length monitor for the half-period check.
  logic [15:0] low_len;
  always_ff @(posedge clk) begin
    if (!rst_n || mdc_q) low_len <= '0;
    else                 low_len <= low_len + 16'd1;
  end

  assert_mdc_low_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> ($past(low_len) == 16'(HALF - 1)));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic [4:0]        req_reg,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  input  logic [4:0]        addr_offset,
  input  logic              bit_start,
  input  logic              sample_tick,
  input  logic              bit_end,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [FRAME_BITS-1:0] frame;
  logic [5:0]            idx;
  logic                  is_wr;
  logic [15:0]           shreg, sh_next;
  logic                  take_bit;

  assign take_bit = sample_tick && !is_wr && (idx >= 6'(DATA_BIT));
  assign sh_next  = take_bit ? {shreg[14:0], mdio_i} : shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      frame   <= '0;
      idx     <= '0;
      is_wr   <= 1'b0;
      shreg   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy  <= 1'b1;
          idx   <= '0;
          is_wr <= req_write;
          frame <= make_frame(req_write, bus_addr(5'(req_port), addr_offset), req_reg, req_wdata);
        end
      end else begin
        shreg <= sh_next;
        if (bit_start) begin
          mdio_o  <= frame[FRAME_BITS-1];
          mdio_oe <= is_wr || (idx < 6'(TA_BIT));
          frame   <= {frame[FRAME_BITS-2:0], 1'b0};
        end
        if (bit_end) begin
          if (idx == 6'(FRAME_BITS - 1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            if (!is_wr) rd_data <= sh_next;
          end else begin
            idx <= idx + 6'd1;
          end
        end
      end
    end
  end

  assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_wr && idx >= 6'(TA_BIT + 1)) |-> !mdio_oe);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_no_retarget_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(is_wr));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data));
endmodule

// File: rtl/mdio_port_master.sv
module mdio_port_master
  import mdio_pkg::*;
#(
  parameter int          PORT_W     = 2,
  parameter int unsigned SYS_CLK_HZ = 50_000_000,
  parameter int unsigned MDC_HALF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic [4:0]        req_reg,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  input  logic [4:0]        addr_offset,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int unsigned FLOOR_HALF = min_half(SYS_CLK_HZ);
  localparam int unsigned HALF_EFF   = (MDC_HALF < FLOOR_HALF) ? FLOOR_HALF : MDC_HALF;

  logic bit_start, sample_tick, bit_end;

  mdio_mdc_gen #(.HALF(HALF_EFF)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc),
    .bit_start(bit_start), .sample_tick(sample_tick), .bit_end(bit_end)
  );

  mdio_frame_seq #(.PORT_W(PORT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_reg(req_reg), .req_write(req_write), .req_wdata(req_wdata),
    .addr_offset(addr_offset), .bit_start(bit_start), .sample_tick(sample_tick),
    .bit_end(bit_end), .mdio_i(mdio_i), .busy(busy), .done(done),
    .rd_data(rd_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  assert_mdc_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mdc);
  assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  assert_drive_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ({mdio_oe, mdio_o} != $past({mdio_oe, mdio_o}))) |-> !mdc);
endmodule

// File: tb/test_mdio_port_master.sv
module test_mdio_port_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_port = '0;
  logic [4:0] req_reg = '0, addr_offset = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i_r = 1'b1;

  always #10 clk = ~clk;

  mdio_port_master i_mdio_port_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_reg(req_reg), .req_write(req_write), .req_wdata(req_wdata),
    .addr_offset(addr_offset), .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i_r)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  // PHY model and bus monitors
  wire line = mdio_oe ? mdio_o : mdio_i_r;
  int nbits = 0, cyc = 0, last_rise = 0, per_min = 1000, per_max = 0;
  int contention = 0, early_moves = 0;
  logic [63:0] cap = '0;
  logic [15:0] phy_val = '0;
  bit phy_rd = 0, phy_drv = 0;
  logic [1:0] prev_drv = 2'b00;

  always @(posedge clk) cyc++;
  always @(posedge mdc) begin
    if (nbits > 0) begin
      if (cyc - last_rise < per_min) per_min = cyc - last_rise;
      if (cyc - last_rise > per_max) per_max = cyc - last_rise;
    end
    last_rise = cyc;
    cap = {cap[62:0], line};
    nbits++;
  end
  always @(negedge mdc) begin
    if (phy_rd && nbits >= 48 && nbits < 64) begin
      mdio_i_r = phy_val[63 - nbits];
      phy_drv  = 1;
    end
  end
  always @(negedge clk) begin
    if (mdio_oe && phy_drv) contention++;
    if (busy && mdc && ({mdio_oe, mdio_o} != prev_drv)) early_moves++;
    prev_drv = {mdio_oe, mdio_o};
  end

  logic [15:0] last_rd = '0;

  task automatic run_txn(input bit wr, input logic [1:0] port, input logic [4:0] rg,
                         input logic [4:0] off, input logic [15:0] wd, input logic [15:0] pv,
                         input bit inject);
    logic [4:0]  ea;
    logic [63:0] ef;
    int wait_n;
    ea = 5'((int'(off) + int'(port)) % 32);
    ef = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), ea, rg, (wr ? 2'b10 : 2'b11), (wr ? wd : pv)};
    nbits = 0; cap = '0; per_min = 1000; per_max = 0; contention = 0; early_moves = 0;
    phy_val = pv; phy_rd = !wr; phy_drv = 0; mdio_i_r = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_port = port; req_reg = rg;
    addr_offset = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    if (inject) begin
      repeat (40) @(negedge clk);
      req_valid = 1'b1; req_write = ~wr; req_port = ~port; req_reg = ~rg;
      addr_offset = ~off; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done == 1'b1 && busy == 1'b0, "R10 done with busy low", {62'd0, done, busy}, 64'h2);
    chk(cap == ef, wr ? "R6/R5 write frame" : "R7/R5 read frame", cap, ef);
    chk(nbits == 64, "R6 bit count", 64'(nbits), 64'd64);
    chk(per_min == 4 && per_max == 4, "R1 MDC period", 64'(per_max), 64'd4);
    chk(contention == 0, "R7 no contention", 64'(contention), 64'd0);
    chk(early_moves == 0, "R3 drive only on falling edge", 64'(early_moves), 64'd0);
    if (!wr) last_rd = pv;
    chk(rd_data == last_rd, wr ? "R11 rd_data kept over write" : "R8 read data", 64'(rd_data), 64'(last_rd));
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", 64'(done), 64'd0);
    chk(mdc == 1'b1 && mdio_oe == 1'b0, "R2/R4 idle bus", {62'd0, mdc, mdio_oe}, 64'h2);
  endtask

  // {write, port, reg, offset, wdata, phy value}
  localparam logic [44:0] VEC [7] = '{
    {1'b1, 2'd0, 5'h00, 5'h00, 16'h1234, 16'h0000},
    {1'b0, 2'd1, 5'h01, 5'h00, 16'h0000, 16'hBEEF},
    {1'b1, 2'd3, 5'h1F, 5'h1E, 16'hA5A5, 16'h0000},
    {1'b0, 2'd2, 5'h10, 5'h1F, 16'h0000, 16'h0001},
    {1'b1, 2'd1, 5'h09, 5'h10, 16'hFFFF, 16'h0000},
    {1'b0, 2'd3, 5'h00, 5'h1C, 16'h0000, 16'h8000},
    {1'b0, 2'd0, 5'h02, 5'h05, 16'h0000, 16'h5A3C}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R10 reset flags", {62'd0, busy, done}, 64'd0);
    chk(mdc == 1'b1, "R2 MDC high in reset", 64'(mdc), 64'd1);
    chk(mdio_oe == 1'b0, "R4 released in reset", 64'(mdio_oe), 64'd0);
    chk(rd_data == 16'h0, "R11 rd_data reset", 64'(rd_data), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mdc == 1'b1 && busy == 1'b0, "R2 idle after reset", {62'd0, mdc, busy}, 64'h2);
    for (int k = 0; k < 7; k++)
      run_txn(VEC[k][44], VEC[k][43:42], VEC[k][41:37], VEC[k][36:32], VEC[k][31:16], VEC[k][15:0], 1'b0);
    // R9: request during a frame must not disturb it
    run_txn(1'b1, 2'd2, 5'h0A, 5'h03, 16'hC3C3, 16'h0000, 1'b1);
    run_txn(1'b0, 2'd1, 5'h07, 5'h1F, 16'h0000, 16'h6E91, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual %0d expected 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule